// File: doc/BRIEF.md
# Display Panel Reset Pulse Sequencer

This block drives the active-low hardware reset line of an attached display panel. Software supplies three values together with a one-cycle start strobe: the length of one low pulse in timer ticks, the number of pulses minus one, and a 4-bit prescaler exponent. A timer tick lasts 2^ratio module clock cycles. The block then produces the programmed pulse train on its reset output. Pulses are separated by a single high tick.

When the last pulse ends, the reset output returns high for good and a sticky completion flag sets. Software clears the flag by pulsing a write-one-to-clear input. A mask input gates the flag onto an interrupt output. Issuing several pulses lets software stretch a reset beyond the longest single pulse, which is 64 ticks. Typical software settings use a prescaler exponent of 15 for long resets.

Top module: `panel_reset_seq`

## Requirements
- R1: After reset the reset output is high, the busy output is low and the completion flag and interrupt are low. Whenever no sequence is running, the reset output is high.
- R2: Each low pulse lasts exactly (width_i + 1) ticks, where width_i is a 6-bit value. With width_i = 63 a pulse lasts 64 ticks.
- R3: One tick lasts exactly 2^ratio_i module clock cycles, where ratio_i is a 4-bit value. The prescaler restarts at the start strobe, so the first pulse has its full programmed length.
- R4: A sequence consists of (count_i + 1) low pulses. Consecutive pulses are separated by a high interval of exactly one tick.
- R5: The completion flag rises on the same clock edge on which the last pulse ends and busy falls. It then stays set.
- R6: A one on done_clr_i clears the flag at the next edge. If completion and clear fall in the same cycle, the flag ends up set.
- R7: The interrupt output equals the completion flag while done_mask_i is 0, and is held low while done_mask_i is 1.
- R8: A start strobe that arrives while a sequence runs is ignored, together with its width, count and ratio. The running sequence completes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that launches a sequence |
| width_i | input | 6 | Low pulse length in ticks, minus one |
| count_i | input | 3 | Number of pulses, minus one |
| ratio_i | input | 4 | Tick length exponent: 2^ratio_i clock cycles |
| done_clr_i | input | 1 | Write-one-to-clear for the completion flag |
| done_mask_i | input | 1 | 1 masks the completion interrupt |
| panel_rst_n_o | output | 1 | Active-low reset to the panel |
| busy_o | output | 1 | High while a sequence runs |
| done_o | output | 1 | Sticky completion flag |
| done_irq_o | output | 1 | Completion flag gated by the mask |

## Verification
Two events can collide on the completion flag: the set from the ending of the last pulse and a software clear. With a one-tick pulse at ratio 0, the ending falls exactly one cycle after the start edge. The bench raises done_clr_i in that cycle and expects the flag to be set afterwards. A second collision is between a running sequence and a new start strobe. The bench issues one with different settings partway through a pulse, then measures every low and high interval to confirm that only the original settings shaped the waveform.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int unsigned WIDTH_W = 6;
    localparam int unsigned SEQ_W   = 3;
    localparam int unsigned RATIO_W = 4;

    typedef enum logic [1:0] {
        PRS_IDLE  = 2'd0,
        PRS_PULSE = 2'd1,
        PRS_GAP   = 2'd2
    } prs_state_e;

    // Prescaler counter width needed for the largest exponent.
    function automatic int unsigned pre_width(input int unsigned ratio_w);
        return (1 << ratio_w) - 1;
    endfunction

endpackage

// File: rtl/prs_prescaler.sv
module prs_prescaler #(
    parameter int unsigned RATIO_W = prs_pkg::RATIO_W,
    localparam int unsigned PRE_W  = prs_pkg::pre_width(RATIO_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // 2^ratio - 1, built by shifting an all-ones vector.
    assign limit  = {PRE_W{1'b1}} >> (PRE_W - int'(ratio_i));
    assign tick_o = !clear_i && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear_i || tick_o) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/prs_pulse_fsm.sv
module prs_pulse_fsm #(
    parameter int unsigned WIDTH_W = prs_pkg::WIDTH_W,
    parameter int unsigned SEQ_W   = prs_pkg::SEQ_W,
    parameter int unsigned RATIO_W = prs_pkg::RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [SEQ_W-1:0]   count_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               tick_i,
    output logic               pre_clr_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               rst_n_o,
    output logic               busy_o,
    output logic               finish_o
);
    import prs_pkg::*;

    prs_state_e         st_q;
    logic [WIDTH_W-1:0] width_q, wid_cnt_q;
    logic [SEQ_W-1:0]   count_q, seq_cnt_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               rst_n_q;
    logic               pulse_end;

    assign pulse_end = (st_q == PRS_PULSE) && tick_i && (wid_cnt_q == width_q);
    assign finish_o  = pulse_end && (seq_cnt_q == count_q);
    assign pre_clr_o = (st_q == PRS_IDLE);
    assign ratio_o   = ratio_q;
    assign rst_n_o   = rst_n_q;
    assign busy_o    = (st_q != PRS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= PRS_IDLE;
            rst_n_q   <= 1'b1;
            width_q   <= '0;
            count_q   <= '0;
            ratio_q   <= '0;
            wid_cnt_q <= '0;
            seq_cnt_q <= '0;
        end else begin
            unique case (st_q)
                PRS_IDLE: begin
                    if (start_i) begin
                        width_q   <= width_i;
                        count_q   <= count_i;
                        ratio_q   <= ratio_i;
                        wid_cnt_q <= '0;
                        seq_cnt_q <= '0;
                        rst_n_q   <= 1'b0;
                        st_q      <= PRS_PULSE;
                    end
                end
                PRS_PULSE: begin
                    if (pulse_end) begin
                        rst_n_q <= 1'b1;
                        st_q    <= finish_o ? PRS_IDLE : PRS_GAP;
                    end else if (tick_i) begin
                        wid_cnt_q <= wid_cnt_q + 1'b1;
                    end
                end
                PRS_GAP: begin
                    if (tick_i) begin
                        rst_n_q   <= 1'b0;
                        wid_cnt_q <= '0;
                        seq_cnt_q <= seq_cnt_q + 1'b1;
                        st_q      <= PRS_PULSE;
                    end
                end
                default: st_q <= PRS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prs_done_flag.sv
module prs_done_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic done_o,
    output logic irq_o
);
    logic done_q;

    // Completion has priority over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst)        done_q <= 1'b0;
        else if (set_i) done_q <= 1'b1;
        else if (clr_i) done_q <= 1'b0;
    end

    assign done_o = done_q;
    assign irq_o  = done_q && !mask_i;
endmodule

// File: rtl/panel_reset_seq.sv
module panel_reset_seq #(
    parameter int unsigned WIDTH_W = prs_pkg::WIDTH_W,
    parameter int unsigned SEQ_W   = prs_pkg::SEQ_W,
    parameter int unsigned RATIO_W = prs_pkg::RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic [SEQ_W-1:0]   count_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               done_clr_i,
    input  logic               done_mask_i,
    output logic               panel_rst_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               done_irq_o
);
    logic               tick;
    logic               pre_clr;
    logic               finish;
    logic [RATIO_W-1:0] ratio_run;

    prs_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear_i (pre_clr),
        .ratio_i (ratio_run),
        .tick_o  (tick)
    );

    prs_pulse_fsm #(
        .WIDTH_W (WIDTH_W),
        .SEQ_W   (SEQ_W),
        .RATIO_W (RATIO_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .width_i   (width_i),
        .count_i   (count_i),
        .ratio_i   (ratio_i),
        .tick_i    (tick),
        .pre_clr_o (pre_clr),
        .ratio_o   (ratio_run),
        .rst_n_o   (panel_rst_n_o),
        .busy_o    (busy_o),
        .finish_o  (finish)
    );

    prs_done_flag u_done (
        .clk    (clk),
        .rst    (rst),
        .set_i  (finish),
        .clr_i  (done_clr_i),
        .mask_i (done_mask_i),
        .done_o (done_o),
        .irq_o  (done_irq_o)
    );
endmodule

// File: rtl/prs_checker.sv
module prs_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic done_clr_i,
    input logic done_mask_i,
    input logic panel_rst_n_o,
    input logic busy_o,
    input logic done_o,
    input logic done_irq_o
);
    // R1: reset line is high whenever no sequence runs
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> panel_rst_n_o);

    // R4: a falling edge of the reset line only occurs inside a sequence
    assert_low_in_seq_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(panel_rst_n_o) |-> busy_o);

    // R5: the flag rises together with the end of busy
    assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($fell(busy_o) && panel_rst_n_o));

    // R6: the flag holds unless cleared
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !done_clr_i) |=> done_o);

    // R6: a clear outside a running sequence takes effect
    assert_done_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (done_clr_i && !busy_o) |=> !done_o);

    // R7: masked interrupt stays low
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        done_mask_i |-> !done_irq_o);

    // R8: a start while running does not restart the line
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && panel_rst_n_o) |=> (panel_rst_n_o || busy_o));
endmodule

bind panel_reset_seq prs_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .done_clr_i    (done_clr_i),
    .done_mask_i   (done_mask_i),
    .panel_rst_n_o (panel_rst_n_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .done_irq_o    (done_irq_o)
);

// File: tb/panel_reset_seq_bench.sv
module panel_reset_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [5:0] width_i = '0;
    logic [2:0] count_i = '0;
    logic [3:0] ratio_i = '0;
    logic       done_clr_i = 1'b0;
    logic       done_mask_i = 1'b0;
    logic       panel_rst_n_o, busy_o, done_o, done_irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    panel_reset_seq u_panel_reset_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .width_i       (width_i),
        .count_i       (count_i),
        .ratio_i       (ratio_i),
        .done_clr_i    (done_clr_i),
        .done_mask_i   (done_mask_i),
        .panel_rst_n_o (panel_rst_n_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .done_irq_o    (done_irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_done();
        @(negedge clk);
        done_clr_i = 1'b1;
        @(negedge clk);
        done_clr_i = 1'b0;
    endtask

    // Launch a sequence and measure every interval; poke >= 0 issues a
    // conflicting start strobe at that sample index.
    task automatic run_seq(input int w, input int s, input int r, input int poke,
                           input string req);
        int level = 0;
        int run = 0;
        int pulses = 0;
        int idx = 0;
        bit timeout = 1'b0;
        @(negedge clk);
        width_i = 6'(w); count_i = 3'(s); ratio_i = 4'(r);
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        forever begin
            @(negedge clk);
            if (idx == poke) begin
                start_i = 1'b1; width_i = 6'd0; count_i = 3'd0; ratio_i = 4'd0;
            end else begin
                start_i = 1'b0;
            end
            idx++;
            if (int'(panel_rst_n_o) == level) begin
                run++;
            end else begin
                if (level == 0) begin
                    check({req, " R2 R3 low length"}, run, (w + 1) << r);
                    pulses++;
                end else begin
                    check({req, " R4 gap length"}, run, 1 << r);
                end
                level = int'(panel_rst_n_o);
                run = 1;
            end
            if (!busy_o) break;
            if (idx > 20000) begin timeout = 1'b1; break; end
        end
        start_i = 1'b0;
        check({req, " watchdog"}, int'(timeout), 0);
        check({req, " R4 pulse count"}, pulses, s + 1);
        check({req, " R5 done at end"}, int'(done_o), 1);
        check({req, " R1 line high at end"}, int'(panel_rst_n_o), 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 reset line", int'(panel_rst_n_o), 1);
        check("R1 reset busy", int'(busy_o), 0);
        check("R1 reset done", int'(done_o), 0);
        check("R1 reset irq", int'(done_irq_o), 0);
    endtask

    task automatic test_flag_mask_clear();
        clear_done();
        run_seq(1, 0, 1, -1, "R5 flag");
        repeat (3) @(negedge clk);
        check("R5 flag sticky", int'(done_o), 1);
        check("R7 irq unmasked", int'(done_irq_o), 1);
        done_mask_i = 1'b1;
        #1 check("R7 irq masked", int'(done_irq_o), 0);
        done_mask_i = 1'b0;
        #1 check("R7 irq unmasked again", int'(done_irq_o), 1);
        @(negedge clk);
        done_clr_i = 1'b1;
        @(negedge clk);
        done_clr_i = 1'b0;
        check("R6 clear", int'(done_o), 0);
        check("R6 irq after clear", int'(done_irq_o), 0);
    endtask

    task automatic test_collision();
        clear_done();
        @(negedge clk);
        width_i = 6'd0; count_i = 3'd0; ratio_i = 4'd0;
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        @(negedge clk);
        check("R3 one-cycle pulse low", int'(panel_rst_n_o), 0);
        done_clr_i = 1'b1;
        @(negedge clk);
        done_clr_i = 1'b0;
        check("R6 set wins over clear", int'(done_o), 1);
        check("R5 busy ended", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        clear_done();
        run_seq(3, 0, 1, -1, "R2 w3 r1");
        clear_done();
        run_seq(2, 0, 3, -1, "R3 w2 r3");
        clear_done();
        run_seq(4, 0, 0, -1, "R3 w4 r0");
        clear_done();
        run_seq(1, 2, 2, -1, "R4 three pulses");
        clear_done();
        run_seq(1, 7, 0, -1, "R4 eight pulses");
        clear_done();
        run_seq(63, 0, 0, -1, "R2 max width");
        clear_done();
        run_seq(5, 1, 1, 4, "R8 start ignored");
        test_flag_mask_clear();
        test_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule